// File: doc/BRIEF.md
# Multi-Channel Interrupt Source Aggregator

This block gathers interrupt events from a configurable number of channels (up to 31) plus one group of controller-level error events, and reduces them to a single level-high interrupt line for one execution environment. Every channel owns a status register that latches event pulses, an enable register that decides which latched bits count as pending, and a write-one-to-clear register. The controller group has the same three registers.

A summary register shows at a glance which sources are pending: one bit per channel and a top bit for the controller group. An environment mask with the same layout picks which of those sources may raise the output. Software services the line by reading the summary, reading the status of each flagged source, and writing that value back to the source's clear register.

Status latching is independent of the enables and the mask. The enables and the mask only decide whether a latched bit becomes visible in the summary and on the line, so turning a source off and on again never loses an event.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, all status, enable and mask registers read zero and `irq` is low.
- R2: Summary bit k (k below the channel count) is set when channel k has any status bit that is also set in its enable register. Bit 31 is set when the controller status has any bit that is also enabled. Every other summary bit reads zero.
- R3: A one-cycle pulse on a channel event input sets the matching status bit on the next clock edge, whatever the enable holds. The bit then reads back from that channel's status register.
- R4: Writing a value to a clear register clears exactly the status bits that are one in the value and leaves the rest alone. Writing back the value just read clears every bit that was read as set.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: Controller status bits sit at positions 1 (bus response error), 2 (error), 3 (empty) and 4 (timer) and are set by `ctrl_evt[0]` to `ctrl_evt[3]`. Bit 0 reads zero. The controller enable and clear registers use the same positions.
- R7: A summary source drives `irq` only while its mask bit is set. A mask of zero holds `irq` low. Mask bits with no source behind them read zero.
- R8: `irq` is a registered level. It goes high one clock after an enabled and unmasked status bit is present, and stays high as long as one remains.
- R9: Clearing a channel's enable removes it from the summary but keeps its status. Setting the enable again restores the summary bit.
- R10: Register addresses: summary 0x00 (read-only), mask 0x01, controller status 0x02, controller enable 0x03, controller clear 0x04. Channel n uses 0x10+4n for status, 0x10+4n+1 for enable and 0x10+4n+2 for clear. Writes to status registers have no effect. Clear registers and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ch_evt | input | NUM_CH*6 | Event pulses, 6 per channel, channel n in bits [6n+5:6n] |
| ctrl_evt | input | 4 | Controller events: bus response error, error, empty, timer |
| irq | output | 1 | Level-high interrupt for the environment |

## Verification
A single event is walked through each gate in turn: latched with its enable off, shown in the summary with the mask off, and finally raising the line. This separates a missing status latch from a missing enable or mask term. Partial clears, clears of zero and read-back clears tell a true write-one-to-clear apart from a plain write or a clear-all. A pulse that coincides with its own clear exposes the priority. Events on the lowest, a middle and the highest channel, plus the controller group with all four events at once, check the address map and the summary bit positions, including the unused bits in between.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int CH_EVT_W   = 6;
    localparam int CTRL_EVT_W = 4;
    localparam int CTRL_LSB   = 1;   // controller status occupies bits [4:1]
    localparam int CTRL_SUM   = 31;  // summary / mask bit for the controller
    localparam int CH_STRIDE  = 4;

    localparam logic [ADDR_W-1:0] A_SUMMARY = 8'h00;
    localparam logic [ADDR_W-1:0] A_MASK    = 8'h01;
    localparam logic [ADDR_W-1:0] A_CSTAT   = 8'h02;
    localparam logic [ADDR_W-1:0] A_CEN     = 8'h03;
    localparam logic [ADDR_W-1:0] A_CCLR    = 8'h04;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 8'h10;

    typedef enum logic [1:0] {
        OFF_STAT = 2'd0,
        OFF_EN   = 2'd1,
        OFF_CLR  = 2'd2
    } ch_off_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [ADDR_W-1:0] ch_reg_addr(input int unsigned ch, input ch_off_e off);
        return A_CH_BASE + ADDR_W'(ch * CH_STRIDE) + ADDR_W'(off);
    endfunction

    // Bits of the summary / mask layout that have a source behind them.
    function automatic logic [DATA_W-1:0] impl_bits(input int unsigned nch);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int unsigned i = 0; i < nch; i++) v[i] = 1'b1;
        v[CTRL_SUM] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irqagg_src_regs.sv
module irqagg_src_regs #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         en_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         pend
);

    logic [W-1:0] stat_q, en_q, clr_bits, stat_d;

    assign clr_bits = clr_we ? wdata : '0;
    assign stat_d   = (stat_q & ~clr_bits) | evt;   // event wins over clear

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            if (en_we) en_q <= wdata;
        end
    end

    assign stat = stat_q;
    assign en   = en_q;
    assign pend = |(stat_q & en_q);

    a_r5_evt_wins: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

    a_r4_w1c: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((stat & $past(wdata & ~evt)) == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_we && evt == '0) |=> $stable(stat));

endmodule

// File: rtl/irqagg_gate.sv
module irqagg_gate
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] ch_pend,
    input  logic              ctrl_pend,
    output logic [DATA_W-1:0] summary,
    output logic [DATA_W-1:0] mask,
    output logic              irq
);

    localparam logic [DATA_W-1:0] IMPL = impl_bits(NUM_CH);

    logic [DATA_W-1:0] mask_q;
    logic              irq_q;

    always_comb begin
        summary               = '0;
        summary[NUM_CH-1:0]   = ch_pend;
        summary[CTRL_SUM]     = ctrl_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (mask_we) mask_q <= wdata & IMPL;
            irq_q <= |(summary & mask_q);
        end
    end

    assign mask = mask_q;
    assign irq  = irq_q;

    a_r7_mask_zero: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !irq);

    a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(summary & mask_q) != '0));

    a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
        ((summary & mask_q) != '0) |=> irq);

endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          summary,
    input  logic [DATA_W-1:0]          mask,
    input  logic [CTRL_EVT_W-1:0]      ctrl_stat,
    input  logic [CTRL_EVT_W-1:0]      ctrl_en,
    input  logic [NUM_CH*CH_EVT_W-1:0] ch_stat,
    input  logic [NUM_CH*CH_EVT_W-1:0] ch_en,
    output logic [DATA_W-1:0]          rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            A_SUMMARY: rdata = summary;
            A_MASK:    rdata = mask;
            A_CSTAT:   rdata[CTRL_LSB +: CTRL_EVT_W] = ctrl_stat;
            A_CEN:     rdata[CTRL_LSB +: CTRL_EVT_W] = ctrl_en;
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (addr == ch_reg_addr(c, OFF_STAT))
                        rdata[CH_EVT_W-1:0] = ch_stat[c*CH_EVT_W +: CH_EVT_W];
                    if (addr == ch_reg_addr(c, OFF_EN))
                        rdata[CH_EVT_W-1:0] = ch_en[c*CH_EVT_W +: CH_EVT_W];
                end
            end
        endcase
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 8   // 1 to 31
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_we,
    input  logic [7:0]                 reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic [NUM_CH*6-1:0]        ch_evt,
    input  logic [3:0]                 ctrl_evt,
    output logic                       irq
);

    localparam int FLAT_W = NUM_CH * CH_EVT_W;

    reg_req_t req;
    assign req = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    logic [FLAT_W-1:0]     ch_stat, ch_en;
    logic [NUM_CH-1:0]     ch_pend;
    logic [CTRL_EVT_W-1:0] ctrl_stat, ctrl_en;
    logic                  ctrl_pend;
    logic [DATA_W-1:0]     summary, mask;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic en_we, clr_we;
        assign en_we  = req.we && (req.addr == ch_reg_addr(c, OFF_EN));
        assign clr_we = req.we && (req.addr == ch_reg_addr(c, OFF_CLR));

        irqagg_src_regs #(.W(CH_EVT_W)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .evt    (ch_evt[c*CH_EVT_W +: CH_EVT_W]),
            .en_we  (en_we),
            .clr_we (clr_we),
            .wdata  (req.wdata[CH_EVT_W-1:0]),
            .stat   (ch_stat[c*CH_EVT_W +: CH_EVT_W]),
            .en     (ch_en[c*CH_EVT_W +: CH_EVT_W]),
            .pend   (ch_pend[c])
        );
    end

    irqagg_src_regs #(.W(CTRL_EVT_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .evt    (ctrl_evt),
        .en_we  (req.we && req.addr == A_CEN),
        .clr_we (req.we && req.addr == A_CCLR),
        .wdata  (req.wdata[CTRL_LSB +: CTRL_EVT_W]),
        .stat   (ctrl_stat),
        .en     (ctrl_en),
        .pend   (ctrl_pend)
    );

    irqagg_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .mask_we   (req.we && req.addr == A_MASK),
        .wdata     (req.wdata),
        .ch_pend   (ch_pend),
        .ctrl_pend (ctrl_pend),
        .summary   (summary),
        .mask      (mask),
        .irq       (irq)
    );

    irqagg_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .addr      (req.addr),
        .summary   (summary),
        .mask      (mask),
        .ctrl_stat (ctrl_stat),
        .ctrl_en   (ctrl_en),
        .ch_stat   (ch_stat),
        .ch_en     (ch_en),
        .rdata     (reg_rdata)
    );

    // R2: the summary never shows a source whose pending line is low
    a_r2_summary_src: assert property (@(posedge clk) disable iff (rst)
        (ch_pend == '0 && !ctrl_pend) |-> (reg_addr != A_SUMMARY || reg_rdata == '0));

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           reg_we;
    logic [7:0]     reg_addr;
    logic [31:0]    reg_wdata;
    logic [31:0]    reg_rdata;
    logic [NCH*6-1:0] ch_evt;
    logic [3:0]     ctrl_evt;
    logic           irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_aggregator #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_evt(ch_evt),
        .ctrl_evt(ctrl_evt), .irq(irq)
    );

    function automatic logic [7:0] cha(int ch, int off);
        return 8'(8'h10 + ch * 4 + off);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_ch(int ch, logic [5:0] bits);
        @(negedge clk);
        ch_evt[ch*6 +: 6] = bits;
        @(negedge clk);
        ch_evt = '0;
    endtask

    task automatic pulse_ctrl(logic [3:0] bits);
        @(negedge clk);
        ctrl_evt = bits;
        @(negedge clk);
        ctrl_evt = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk("R1 summary after reset", v, 32'h0);
        rd(8'h01, v); chk("R1 mask after reset", v, 32'h0);
        rd(cha(0, 0), v); chk("R1 ch0 status after reset", v, 32'h0);
        rd(8'h03, v); chk("R1 ctrl enable after reset", v, 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);
    endtask

    task automatic t_gating;
        logic [31:0] v;
        pulse_ch(2, 6'h01);
        rd(cha(2, 0), v); chk("R3 event latched with enable off", v, 32'h01);
        rd(8'h00, v); chk("R2 disabled status not in summary", v, 32'h0);
        wr(cha(2, 1), 32'h01);
        rd(8'h00, v); chk("R2 enabled ch2 in summary", v, 32'h4);
        tick(2);
        chk("R7 masked source keeps irq low", 32'(irq), 32'h0);
        wr(8'h01, 32'h4);
        tick(1);
        chk("R8 irq rises after mask set", 32'(irq), 32'h1);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        pulse_ch(2, 6'h30);
        rd(cha(2, 0), v); chk("R3 second event ORed in", v, 32'h31);
        wr(cha(2, 2), 32'h10);
        rd(cha(2, 0), v); chk("R4 partial clear", v, 32'h21);
        wr(cha(2, 2), 32'h0);
        rd(cha(2, 0), v); chk("R4 clear of zero keeps status", v, 32'h21);
        tick(1);
        chk("R8 irq held while enabled bit set", 32'(irq), 32'h1);
        rd(cha(2, 0), v);
        wr(cha(2, 2), v);
        rd(cha(2, 0), v); chk("R4 read-back clear empties status", v, 32'h0);
        tick(1);
        chk("R8 irq drops after clear", 32'(irq), 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        pulse_ch(5, 6'h09);
        rd(cha(5, 0), v); chk("R3 ch5 status", v, 32'h09);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = cha(5, 2); reg_wdata = 32'h09;
        ch_evt[5*6 +: 6] = 6'h08;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; ch_evt = '0;
        rd(cha(5, 0), v); chk("R5 event beats same-cycle clear", v, 32'h08);
        wr(cha(5, 2), 32'h08);
        rd(cha(5, 0), v); chk("R4 ch5 cleared", v, 32'h0);
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        pulse_ctrl(4'b0010);
        rd(8'h02, v); chk("R6 error event at bit 2", v, 32'h04);
        rd(8'h00, v); chk("R2 ctrl disabled not in summary", v, 32'h0);
        wr(8'h03, 32'h04);
        rd(8'h00, v); chk("R2 ctrl pending at bit 31", v, 32'h8000_0000);
        wr(8'h01, 32'h8000_0004);
        tick(1);
        chk("R7 ctrl source unmasked raises irq", 32'(irq), 32'h1);
        wr(8'h04, 32'h04);
        rd(8'h02, v); chk("R6 ctrl clear at bit 2", v, 32'h0);
        tick(1);
        chk("R8 irq low after ctrl clear", 32'(irq), 32'h0);
        pulse_ctrl(4'hF);
        rd(8'h02, v); chk("R6 all ctrl events at bits 4:1", v, 32'h1E);
        wr(8'h04, 32'h1E);
        rd(8'h02, v); chk("R6 all ctrl bits cleared", v, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(cha(1, 0), 32'h3F);
        rd(cha(1, 0), v); chk("R10 status write ignored", v, 32'h0);
        rd(cha(1, 2), v); chk("R10 clear register reads zero", v, 32'h0);
        rd(8'h7F, v); chk("R10 unmapped reads zero", v, 32'h0);
        pulse_ch(7, 6'h02);
        rd(cha(7, 0), v); chk("R10 ch7 status at 0x2C", v, 32'h02);
        wr(cha(7, 1), 32'h02);
        rd(cha(7, 1), v); chk("R10 ch7 enable at 0x2D", v, 32'h02);
        rd(8'h00, v); chk("R2 ch7 only, gap bits zero", v, 32'h80);
        wr(8'h01, 32'hFFFF_FFFF);
        rd(8'h01, v); chk("R7 absent mask bits read zero", v, 32'h8000_00FF);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(cha(7, 1), 32'h0);
        rd(8'h00, v); chk("R9 disabled ch7 leaves summary", v, 32'h0);
        rd(cha(7, 0), v); chk("R9 status kept while disabled", v, 32'h02);
        wr(cha(7, 1), 32'h02);
        rd(8'h00, v); chk("R9 re-enable restores summary", v, 32'h80);
    endtask

    task automatic t_mask;
        tick(1);
        chk("R8 irq with ch7 unmasked", 32'(irq), 32'h1);
        tick(5);
        chk("R8 irq stays high", 32'(irq), 32'h1);
        wr(8'h01, 32'h0);
        tick(1);
        chk("R7 zero mask drops irq", 32'(irq), 32'h0);
        tick(3);
        chk("R7 zero mask holds irq low", 32'(irq), 32'h0);
    endtask

    initial begin
        #500us;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        ch_evt = '0; ctrl_evt = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset;
        t_gating;
        t_w1c;
        t_collide;
        t_ctrl;
        t_map;
        t_enable;
        t_mask;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule